// File: doc/BRIEF.md
# Almost-Full / Almost-Empty Offset Loader

This block produces the two threshold values that a FIFO's programmable flags compare against: the almost-empty offset (X) and the almost-full offset (Y). A two-bit configuration code, present on two shared pins while reset is held, picks one of four loading methods. Two methods apply a built-in preset to both offsets at once. One captures both offsets from two write-side data words. One shifts both offsets in as a single serial stream clocked by the write clock.

After reset is released, the same two pins change meaning. In serial mode the upper pin becomes an active-low shift enable and the lower pin carries the data bit. The stream is exactly twice the pointer width long: Y arrives first, most significant bit first, and X follows. A done output goes high when the chosen method has finished. Write requests only pass through to the FIFO once done is high, so the words used for parallel loading never reach the storage array.

Top module: `ofs_loader`

## Requirements
- R1: The method code {cfg_hi_en_n, cfg_lo_sdat} is sampled on every clock edge while rst_n is low. It is frozen from the first edge at which rst_n is high, and later pin activity does not change the method.
- R2: Method codes: 2'b01 selects preset PRESET_A (default 8), 2'b10 selects preset PRESET_B (default 64), 2'b00 selects parallel load, and 2'b11 selects serial load.
- R3: In a preset method, ae_offset and af_offset both equal the preset, and load_done is high from the first clock edge after reset release.
- R4: In serial mode, one bit is taken from cfg_lo_sdat on each clock edge where cfg_hi_en_n is low. Edges with cfg_hi_en_n high change nothing.
- R5: The serial stream is {Y, X}, sent most significant bit first. af_offset (Y) holds the first PTR_W bits and ae_offset (X) holds the last PTR_W bits, so the final bit is the LSB of X.
- R6: load_done rises after exactly 2*PTR_W serial bits. Further enabled bits leave both offsets unchanged, and load_done stays high.
- R7: In parallel mode, the first accepted write loads af_offset from wr_data[PTR_W-1:0], and the second write loads ae_offset from the same field. load_done rises after the second write, and later writes change nothing.
- R8: fifo_wr_en equals wr_en while load_done is high and is low otherwise. Loading writes are never forwarded.
- R9: While rst_n is low, load_done and fifo_wr_en are low, and the serial and parallel offset values are zero.
- R10: In serial and preset methods, writes do not alter the offsets. In parallel mode, serial pin activity does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Synchronous active-low reset; method latched while low |
| cfg_hi_en_n | input | 1 | Method code upper bit in reset; serial enable (active low) afterwards |
| cfg_lo_sdat | input | 1 | Method code lower bit in reset; serial data afterwards |
| wr_en | input | 1 | Write request from the write port |
| wr_data | input | DATA_W | Write-port data bus |
| ae_offset | output | PTR_W | Almost-empty offset X |
| af_offset | output | PTR_W | Almost-full offset Y |
| load_done | output | 1 | Offsets are programmed |
| fifo_wr_en | output | 1 | Write request passed on to the FIFO |

## Verification
The bench changes the shared pins immediately after reset is released. A design that kept tracking them would switch method or corrupt a preset. It pauses the serial stream mid-way and stops one bit short of the full count. A counter that is off by one, or that shifts on disabled edges, would raise done early or misplace the Y/X boundary. After completion it keeps feeding extra bits and writes, which a design without a hard stop would shift into the offsets. In parallel mode it checks that neither loading write reaches fifo_wr_en and that the Y-then-X order is not swapped.

// File: rtl/ofs_pkg.sv
`timescale 1ns/1ps
package ofs_pkg;
    typedef enum logic [1:0] {
        OFS_PAR   = 2'b00,
        OFS_PRE_A = 2'b01,
        OFS_PRE_B = 2'b10,
        OFS_SER   = 2'b11
    } ofs_mode_e;
endpackage

// File: rtl/ofs_mode_latch.sv
`timescale 1ns/1ps
// Tracks the method pins during reset and holds the code once reset lifts.
module ofs_mode_latch
    import ofs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_hi,
    input  logic      pin_lo,
    output ofs_mode_e mode,
    output logic      live
);
    typedef struct packed {
        ofs_mode_e mode;
        logic      live;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.mode = ofs_mode_e'({pin_hi, pin_lo});
            st_d.live = 1'b0;
        end else begin
            st_d.live = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode = st_q.mode;
    assign live = st_q.live;
endmodule

// File: rtl/ofs_serial_shift.sv
`timescale 1ns/1ps
// Serial offset intake: Y then X, MSB first, fixed bit budget.
module ofs_serial_shift #(
    parameter int PTR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             en_n,
    input  logic             sdat,
    output logic [PTR_W-1:0] y_val,
    output logic [PTR_W-1:0] x_val,
    output logic             done
);
    localparam int SH_W  = 2 * PTR_W;
    localparam int CNT_W = $clog2(SH_W + 1);

    typedef struct packed {
        logic [SH_W-1:0]  sh;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic full;

    assign full = (st_q.cnt == CNT_W'(SH_W));

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else if (active && !en_n && !full) begin
            st_d.sh  = {st_q.sh[SH_W-2:0], sdat};
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign y_val = st_q.sh[SH_W-1:PTR_W];
    assign x_val = st_q.sh[PTR_W-1:0];
    assign done  = full;
endmodule

// File: rtl/ofs_par_capture.sv
`timescale 1ns/1ps
// Parallel offset intake: first write is Y, second is X.
module ofs_par_capture #(
    parameter int PTR_W  = 9,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PTR_W-1:0]  y_val,
    output logic [PTR_W-1:0]  x_val,
    output logic              done
);
    typedef struct packed {
        logic [PTR_W-1:0] y;
        logic [PTR_W-1:0] x;
        logic [1:0]       cnt;
    } st_t;

    st_t  st_d, st_q;
    logic unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:PTR_W];

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else if (active && wr_en && !st_q.cnt[1]) begin
            if (st_q.cnt == 2'd0) st_d.y = wr_data[PTR_W-1:0];
            else                  st_d.x = wr_data[PTR_W-1:0];
            st_d.cnt = st_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign y_val = st_q.y;
    assign x_val = st_q.x;
    assign done  = st_q.cnt[1];
endmodule

// File: rtl/ofs_loader.sv
`timescale 1ns/1ps
// Offset loader top: method select and output steering.
module ofs_loader
    import ofs_pkg::*;
#(
    parameter int PTR_W    = 9,
    parameter int DATA_W   = 36,
    parameter int PRESET_A = 8,
    parameter int PRESET_B = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hi_en_n,
    input  logic              cfg_lo_sdat,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PTR_W-1:0]  ae_offset,
    output logic [PTR_W-1:0]  af_offset,
    output logic              load_done,
    output logic              fifo_wr_en
);
    localparam logic [PTR_W-1:0] PRE_A_V = PTR_W'(PRESET_A);
    localparam logic [PTR_W-1:0] PRE_B_V = PTR_W'(PRESET_B);

    ofs_mode_e        mode;
    logic             live;
    logic [PTR_W-1:0] ser_y, ser_x, par_y, par_x;
    logic             ser_done, par_done;

    ofs_mode_latch u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_hi (cfg_hi_en_n),
        .pin_lo (cfg_lo_sdat),
        .mode   (mode),
        .live   (live)
    );

    ofs_serial_shift #(.PTR_W(PTR_W)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (mode == OFS_SER),
        .en_n   (cfg_hi_en_n),
        .sdat   (cfg_lo_sdat),
        .y_val  (ser_y),
        .x_val  (ser_x),
        .done   (ser_done)
    );

    ofs_par_capture #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (mode == OFS_PAR),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .y_val   (par_y),
        .x_val   (par_x),
        .done    (par_done)
    );

    always_comb begin
        unique case (mode)
            OFS_PRE_A: begin
                ae_offset = PRE_A_V;
                af_offset = PRE_A_V;
                load_done = live;
            end
            OFS_PRE_B: begin
                ae_offset = PRE_B_V;
                af_offset = PRE_B_V;
                load_done = live;
            end
            OFS_SER: begin
                ae_offset = ser_x;
                af_offset = ser_y;
                load_done = ser_done;
            end
            default: begin
                ae_offset = par_x;
                af_offset = par_y;
                load_done = par_done;
            end
        endcase
    end

    assign fifo_wr_en = wr_en & load_done;
endmodule

// File: rtl/ofs_loader_chk.sv
`timescale 1ns/1ps
module ofs_loader_chk #(
    parameter int PTR_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             cfg_hi_en_n,
    input logic             wr_en,
    input logic [PTR_W-1:0] ae_offset,
    input logic [PTR_W-1:0] af_offset,
    input logic             load_done,
    input logic             fifo_wr_en
);
    // R1: method code does not move once out of reset
    a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode));

    // R3: presets complete on the first edge after release
    a_r3_preset_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ofs_pkg::OFS_PRE_A || mode == ofs_pkg::OFS_PRE_B) |=> load_done);

    // R4: disabled serial edges leave the offsets alone
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ofs_pkg::OFS_SER && cfg_hi_en_n) |=> ($stable(ae_offset) && $stable(af_offset)));

    // R6: completion is permanent and freezes the values
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> (load_done && $stable(ae_offset) && $stable(af_offset)));

    // R8: nothing reaches the FIFO before programming completes
    a_r8_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> (load_done && wr_en));
endmodule

bind ofs_loader ofs_loader_chk #(.PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .cfg_hi_en_n (cfg_hi_en_n),
    .wr_en       (wr_en),
    .ae_offset   (ae_offset),
    .af_offset   (af_offset),
    .load_done   (load_done),
    .fifo_wr_en  (fifo_wr_en)
);

// File: tb/ofs_loader_test.sv
`timescale 1ns/1ps
module ofs_loader_test;
    localparam int PTR_W  = 9;
    localparam int DATA_W = 36;
    localparam int SH_W   = 2 * PTR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_hi_en_n = 1'b0;
    logic              cfg_lo_sdat = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [PTR_W-1:0]  ae_offset, af_offset;
    logic              load_done, fifo_wr_en;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ofs_loader #(.PTR_W(PTR_W), .DATA_W(DATA_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_hi_en_n (cfg_hi_en_n),
        .cfg_lo_sdat (cfg_lo_sdat),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .ae_offset   (ae_offset),
        .af_offset   (af_offset),
        .load_done   (load_done),
        .fifo_wr_en  (fifo_wr_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_val(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    // Hold reset with the given method code, then release at a falling edge.
    task automatic do_reset(input logic hi, input logic lo);
        @(negedge clk);
        rst_n = 1'b0; cfg_hi_en_n = hi; cfg_lo_sdat = lo;
        wr_en = 1'b1; wr_data = 36'h0_0000_01FF;
        repeat (4) @(negedge clk);
        chk_val("R9 done low in reset", int'(load_done), 0);
        chk_val("R9 no forward in reset", int'(fifo_wr_en), 0);
        wr_en = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_preset(input logic hi, input logic lo, input int val);
        do_reset(hi, lo);
        cfg_hi_en_n = ~hi; cfg_lo_sdat = ~lo;   // R1: pins change right after release
        @(negedge clk);
        chk_val("R3 done after release", int'(load_done), 1);
        chk_val("R2 R3 ae preset", int'(ae_offset), val);
        chk_val("R2 R3 af preset", int'(af_offset), val);
        wr_en = 1'b1; wr_data = 36'h0_0000_0005;
        #1 chk_val("R8 forward when done", int'(fifo_wr_en), 1);
        repeat (3) @(negedge clk);
        chk_val("R10 R1 ae kept", int'(ae_offset), val);
        chk_val("R10 R1 af kept", int'(af_offset), val);
        wr_en = 1'b0;
    endtask

    task automatic t_serial(input logic [PTR_W-1:0] y, input logic [PTR_W-1:0] x);
        logic [SH_W-1:0] bits;
        bits = {y, x};
        do_reset(1'b1, 1'b1);
        cfg_hi_en_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            cfg_lo_sdat = k[0];
            wr_en = 1'b1; wr_data = 36'h0_0000_0123;
            #1 chk_val("R8 no forward while serial", int'(fifo_wr_en), 0);
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk_val("R4 R10 idle ae", int'(ae_offset), 0);
        chk_val("R4 R10 idle af", int'(af_offset), 0);
        for (int i = SH_W - 1; i >= 0; i--) begin
            if (i == 9) begin
                cfg_hi_en_n = 1'b1; cfg_lo_sdat = ~bits[i];
                @(negedge clk);
            end
            if (i == 0) chk_val("R6 not done one bit short", int'(load_done), 0);
            cfg_hi_en_n = 1'b0; cfg_lo_sdat = bits[i];
            @(negedge clk);
        end
        chk_val("R6 done after full count", int'(load_done), 1);
        chk_val("R5 af holds Y", int'(af_offset), int'(y));
        chk_val("R5 ae holds X", int'(ae_offset), int'(x));
        cfg_lo_sdat = 1'b1;
        repeat (5) @(negedge clk);
        chk_val("R6 extra bits ignored af", int'(af_offset), int'(y));
        chk_val("R6 extra bits ignored ae", int'(ae_offset), int'(x));
        chk_val("R6 done stays", int'(load_done), 1);
        cfg_hi_en_n = 1'b1;
    endtask

    task automatic t_parallel(input logic [DATA_W-1:0] d1, input logic [DATA_W-1:0] d2);
        do_reset(1'b0, 1'b0);
        cfg_hi_en_n = 1'b0; cfg_lo_sdat = 1'b1;
        repeat (3) @(negedge clk);
        chk_val("R10 serial pins ignored", int'(af_offset), 0);
        chk_val("R7 no done before writes", int'(load_done), 0);
        wr_en = 1'b1; wr_data = d1;
        #1 chk_val("R8 first load not forwarded", int'(fifo_wr_en), 0);
        @(negedge clk);
        chk_val("R7 first write to af", int'(af_offset), int'(d1[PTR_W-1:0]));
        chk_val("R7 not done after one", int'(load_done), 0);
        wr_data = d2;
        #1 chk_val("R8 second load not forwarded", int'(fifo_wr_en), 0);
        @(negedge clk);
        chk_val("R7 second write to ae", int'(ae_offset), int'(d2[PTR_W-1:0]));
        chk_val("R7 done after two", int'(load_done), 1);
        wr_data = ~d1;
        #1 chk_val("R8 forward after load", int'(fifo_wr_en), 1);
        @(negedge clk);
        chk_val("R7 later write ignored af", int'(af_offset), int'(d1[PTR_W-1:0]));
        chk_val("R7 later write ignored ae", int'(ae_offset), int'(d2[PTR_W-1:0]));
        wr_en = 1'b0;
        #1 chk_val("R8 idle no forward", int'(fifo_wr_en), 0);
    endtask

    task automatic t_reset_clear();
        @(negedge clk);
        rst_n = 1'b0; cfg_hi_en_n = 1'b1; cfg_lo_sdat = 1'b1;
        @(negedge clk);
        chk_val("R9 serial ae cleared", int'(ae_offset), 0);
        chk_val("R9 serial af cleared", int'(af_offset), 0);
        chk_val("R9 done cleared", int'(load_done), 0);
    endtask

    initial begin
        t_preset(1'b0, 1'b1, 8);
        t_preset(1'b1, 1'b0, 64);
        t_serial(9'h1A5, 9'h05B);
        t_reset_clear();
        t_serial(9'h101, 9'h0FE);
        t_parallel(36'hA_BCDE_F123, 36'h5_4321_0ACE);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule